// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block decides which interrupt a 16550-style UART presents to its host and drives the level interrupt line. It holds the four-bit interrupt enable register and the pending flag for the transmit-holding-empty source. It also holds the sticky break and overrun flags. The other sources arrive as signals from the surrounding UART: parity and framing error levels, the character-timeout flag, receive data-ready with the FIFO fill count and trigger level, transmit-holding-empty status and its "just emptied" event, and the modem delta summary.

Each cycle a fixed five-level priority encoder picks the highest active enabled source. Its four-bit code, together with a FIFO-enabled indication in the top two bits, is registered into the identification register. Host accesses come in as one read or write strobe with a 3-bit register offset. Offsets 0 and 1 are diverted to the divisor latch while the divisor-select input is high. The block applies the side effects of those accesses: a write to the enable register, a write to the holding register, a read of the identification register and a read of the line status register.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is held, and after it, until the first access: enable register 0, identification register 0x01, interrupt output low, break and overrun flags clear.
- R2: A write at offset 1 with divisor-select low stores only data bits 3:0 in the enable register. The write is ignored while divisor-select is high.
- R3: The identification low nibble is the highest active source in this order. Line status (enable bit 2 and any error flag) gives 0x6. Timeout (enable bit 0 and timeout flag) gives 0xC. Receive data gives 0x4. Transmit empty (enable bit 1 and pending flag) gives 0x2. Modem (enable bit 3 and any delta) gives 0x0. With no active source the nibble is 0x1.
- R4: Receive data is active when enable bit 0 and data-ready are set and either the FIFO is disabled or the fill count is at or above the trigger level.
- R5: The character timeout source is masked by enable bit 0, the same bit as receive data.
- R6: Identification bits 7:6 read 11 while the FIFO-enable input is high and 00 otherwise; bits 5:4 read 0.
- R7: The interrupt output is high exactly when the identification low nibble is not 0x1.
- R8: The transmit pending flag is set by an enable-register write while transmit-holding-empty is high, and by the transmit-emptied event.
- R9: A read at offset 2 clears the transmit pending flag only while the identification register shows code 0x2.
- R10: A write at offset 0 with divisor-select low clears the transmit pending flag. A set event in the same cycle wins over any clear.
- R11: The line status flags are break (bit 3), framing (bit 2), parity (bit 1) and overrun (bit 0). A read at offset 5 clears break and overrun; a set pulse in the same cycle wins. Framing and parity follow their inputs.
- R12: The identification register and interrupt output reflect state and inputs present one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_wr_i | input | 1 | Host write strobe |
| acc_rd_i | input | 1 | Host read strobe |
| acc_ofs_i | input | 3 | Register offset of the access |
| acc_wdata_i | input | 8 | Host write data |
| div_sel_i | input | 1 | Offsets 0 and 1 address the divisor latch |
| fifo_en_i | input | 1 | FIFOs enabled |
| rx_ready_i | input | 1 | Receive data ready |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| rx_trig_i | input | CNT_W | Receive trigger level in characters |
| rx_tmo_i | input | 1 | Character timeout pending |
| brk_set_i | input | 1 | Break received pulse |
| ovr_set_i | input | 1 | Overrun pulse |
| par_err_i | input | 1 | Parity error level |
| frm_err_i | input | 1 | Framing error level |
| thr_empty_i | input | 1 | Transmit holding register empty |
| tx_drained_i | input | 1 | Transmitter just emptied the holding register |
| msr_delta_i | input | 1 | Any modem-status delta set |
| ier_o | output | 4 | Enable register |
| iir_o | output | 8 | Identification register |
| lsr_err_o | output | 4 | Break, framing, parity, overrun |
| irq_o | output | 1 | Level interrupt |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a read of the line status register and a new break or overrun pulse. The second pair is a clearing access to the transmit pending flag and the transmit-emptied event. Directed steps drive both in one cycle and require the flag to survive. Random cycles repeat these collisions many times. Each cycle the bench compares the identification value, interrupt and flags with a model stepped from the requirements.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;
  localparam int unsigned IER_W = 4;
  localparam int unsigned ERR_W = 4;

  localparam logic [2:0] OFS_HOLD  = 3'd0;
  localparam logic [2:0] OFS_ENA   = 3'd1;
  localparam logic [2:0] OFS_IDENT = 3'd2;
  localparam logic [2:0] OFS_LSTAT = 3'd5;

  // enable-register bit positions
  localparam int unsigned EN_RX  = 0;
  localparam int unsigned EN_TX  = 1;
  localparam int unsigned EN_LS  = 2;
  localparam int unsigned EN_MDM = 3;

  typedef enum logic [3:0] {
    ID_MODEM = 4'h0,
    ID_NONE  = 4'h1,
    ID_THRE  = 4'h2,
    ID_RXD   = 4'h4,
    ID_LSTAT = 4'h6,
    ID_TMO   = 4'hC
  } irq_id_e;
endpackage

// File: rtl/uart_irq_sticky.sv
`timescale 1ns/1ps
module uart_irq_sticky #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_d, flag_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    // a set pulse in the clearing cycle is kept
    always_comb begin
      flag_d[g] = flag_q[g];
      if (clr_i)    flag_d[g] = 1'b0;
      if (set_i[g]) flag_d[g] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/uart_irq_thr_pend.sv
`timescale 1ns/1ps
module uart_irq_thr_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ena_wr_i,
  input  logic thr_empty_i,
  input  logic tx_drained_i,
  input  logic hold_wr_i,
  input  logic ident_rd_i,
  input  logic shows_thre_i,
  output logic pend_o
);
  logic pend_d, pend_q;
  logic set_w, clr_w;

  assign set_w = (ena_wr_i && thr_empty_i) || tx_drained_i;
  assign clr_w = hold_wr_i || (ident_rd_i && shows_thre_i);

  always_comb begin
    pend_d = pend_q;
    if (clr_w) pend_d = 1'b0;
    if (set_w) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/uart_irq_prio.sv
`timescale 1ns/1ps
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic [IER_W-1:0] ier_i,
  input  logic             err_any_i,
  input  logic             tmo_i,
  input  logic             rx_ready_i,
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic             thr_pend_i,
  input  logic             msr_delta_i,
  output irq_id_e          code_o
);
  logic rx_hit;

  assign rx_hit = rx_ready_i && (!fifo_en_i || (rx_count_i >= rx_trig_i));

  always_comb begin
    code_o = ID_NONE;
    if (ier_i[EN_LS] && err_any_i)        code_o = ID_LSTAT;
    else if (ier_i[EN_RX] && tmo_i)       code_o = ID_TMO;
    else if (ier_i[EN_RX] && rx_hit)      code_o = ID_RXD;
    else if (ier_i[EN_TX] && thr_pend_i)  code_o = ID_THRE;
    else if (ier_i[EN_MDM] && msr_delta_i) code_o = ID_MODEM;
  end
endmodule

// File: rtl/uart_irq_ident.sv
`timescale 1ns/1ps
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_wr_i,
  input  logic             acc_rd_i,
  input  logic [2:0]       acc_ofs_i,
  input  logic [7:0]       acc_wdata_i,
  input  logic             div_sel_i,
  input  logic             fifo_en_i,
  input  logic             rx_ready_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic             rx_tmo_i,
  input  logic             brk_set_i,
  input  logic             ovr_set_i,
  input  logic             par_err_i,
  input  logic             frm_err_i,
  input  logic             thr_empty_i,
  input  logic             tx_drained_i,
  input  logic             msr_delta_i,
  output logic [IER_W-1:0] ier_o,
  output logic [7:0]       iir_o,
  output logic [ERR_W-1:0] lsr_err_o,
  output logic             irq_o
);
  logic             hold_wr, ena_wr, ident_rd, lstat_rd;
  logic [IER_W-1:0] ier_d, ier_q;
  logic [7:0]       iir_d, iir_q;
  logic             irq_d, irq_q;
  logic [1:0]       sticky;
  logic             thr_pend_q;
  irq_id_e          code;

  assign hold_wr  = acc_wr_i && (acc_ofs_i == OFS_HOLD)  && !div_sel_i;
  assign ena_wr   = acc_wr_i && (acc_ofs_i == OFS_ENA)   && !div_sel_i;
  assign ident_rd = acc_rd_i && (acc_ofs_i == OFS_IDENT);
  assign lstat_rd = acc_rd_i && (acc_ofs_i == OFS_LSTAT);

  uart_irq_sticky #(.N(2)) u_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({brk_set_i, ovr_set_i}),
    .clr_i  (lstat_rd),
    .flag_o (sticky)
  );

  assign lsr_err_o = {sticky[1], frm_err_i, par_err_i, sticky[0]};

  uart_irq_thr_pend u_thr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ena_wr_i     (ena_wr),
    .thr_empty_i  (thr_empty_i),
    .tx_drained_i (tx_drained_i),
    .hold_wr_i    (hold_wr),
    .ident_rd_i   (ident_rd),
    .shows_thre_i (iir_q[3:0] == ID_THRE),
    .pend_o       (thr_pend_q)
  );

  uart_irq_prio #(.CNT_W(CNT_W)) u_prio (
    .ier_i       (ier_q),
    .err_any_i   (|lsr_err_o),
    .tmo_i       (rx_tmo_i),
    .rx_ready_i  (rx_ready_i),
    .fifo_en_i   (fifo_en_i),
    .rx_count_i  (rx_count_i),
    .rx_trig_i   (rx_trig_i),
    .thr_pend_i  (thr_pend_q),
    .msr_delta_i (msr_delta_i),
    .code_o      (code)
  );

  always_comb begin
    ier_d = ier_q;
    if (ena_wr) ier_d = acc_wdata_i[IER_W-1:0];
    iir_d = {{2{fifo_en_i}}, 2'b00, code};
    irq_d = (code != ID_NONE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_q <= '0;
      iir_q <= {4'h0, ID_NONE};
      irq_q <= 1'b0;
    end else begin
      ier_q <= ier_d;
      iir_q <= iir_d;
      irq_q <= irq_d;
    end
  end

  assign ier_o = ier_q;
  assign iir_o = iir_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/uart_irq_ident_chk.sv
`timescale 1ns/1ps
module uart_irq_ident_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       acc_wr_i,
  input logic       acc_rd_i,
  input logic [2:0] acc_ofs_i,
  input logic [7:0] acc_wdata_i,
  input logic       div_sel_i,
  input logic       fifo_en_i,
  input logic       brk_set_i,
  input logic       ovr_set_i,
  input logic       tx_drained_i,
  input logic [3:0] ier_o,
  input logic [7:0] iir_o,
  input logic [3:0] lsr_err_o,
  input logic       irq_o,
  input logic       thr_pend
);
  // R7
  a_r7_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (iir_o[3:0] != 4'h1));

  // R2
  a_r2_ier_low_nibble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr_i && acc_ofs_i == 3'd1 && !div_sel_i) |=> ier_o == $past(acc_wdata_i[3:0]));

  a_r2_div_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr_i && acc_ofs_i == 3'd1 && div_sel_i) |=> $stable(ier_o));

  // R6
  a_r6_fifo_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (iir_o[7:6] == {2{$past(fifo_en_i)}}) && (iir_o[5:4] == 2'b00));

  // R3
  a_r3_lstat_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_o[2] && (|lsr_err_o)) |=> iir_o[3:0] == 4'h6);

  // R11
  a_r11_lstat_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_rd_i && acc_ofs_i == 3'd5 && !brk_set_i && !ovr_set_i) |=>
      (!lsr_err_o[3] && !lsr_err_o[0]));

  // R9
  a_r9_ident_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_rd_i && acc_ofs_i == 3'd2 && iir_o[3:0] == 4'h2 && !tx_drained_i) |=> !thr_pend);

  // R10
  a_r10_drain_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_drained_i |=> thr_pend);
endmodule

bind uart_irq_ident uart_irq_ident_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .acc_wr_i     (acc_wr_i),
  .acc_rd_i     (acc_rd_i),
  .acc_ofs_i    (acc_ofs_i),
  .acc_wdata_i  (acc_wdata_i),
  .div_sel_i    (div_sel_i),
  .fifo_en_i    (fifo_en_i),
  .brk_set_i    (brk_set_i),
  .ovr_set_i    (ovr_set_i),
  .tx_drained_i (tx_drained_i),
  .ier_o        (ier_o),
  .iir_o        (iir_o),
  .lsr_err_o    (lsr_err_o),
  .irq_o        (irq_o),
  .thr_pend     (thr_pend_q)
);

// File: tb/uart_irq_ident_tb.sv
`timescale 1ns/1ps
module uart_irq_ident_tb_top;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic acc_wr, acc_rd, div_sel, fifo_en, rx_ready, rx_tmo;
  logic [2:0] acc_ofs;
  logic [7:0] acc_wdata;
  logic [CW-1:0] rx_count, rx_trig;
  logic brk_set, ovr_set, par_err, frm_err, thr_empty, tx_drained, msr_delta;
  logic [3:0] ier;
  logic [7:0] iir;
  logic [3:0] lsr_err;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model state
  logic [3:0] m_ier;
  logic       m_pend, m_brk, m_ovr;
  logic [7:0] m_iir;

  always #4 clk = ~clk;

  uart_irq_ident #(.CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_wr_i(acc_wr), .acc_rd_i(acc_rd),
    .acc_ofs_i(acc_ofs), .acc_wdata_i(acc_wdata), .div_sel_i(div_sel),
    .fifo_en_i(fifo_en), .rx_ready_i(rx_ready), .rx_count_i(rx_count),
    .rx_trig_i(rx_trig), .rx_tmo_i(rx_tmo), .brk_set_i(brk_set),
    .ovr_set_i(ovr_set), .par_err_i(par_err), .frm_err_i(frm_err),
    .thr_empty_i(thr_empty), .tx_drained_i(tx_drained), .msr_delta_i(msr_delta),
    .ier_o(ier), .iir_o(iir), .lsr_err_o(lsr_err), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%02h exp=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  // expected code from R3, R4, R5
  function automatic logic [3:0] exp_code();
    logic errs, rxh;
    errs = m_brk | m_ovr | par_err | frm_err;
    rxh  = rx_ready && (!fifo_en || (rx_count >= rx_trig));
    if (m_ier[2] && errs)           return 4'h6;
    else if (m_ier[0] && rx_tmo)    return 4'hC;
    else if (m_ier[0] && rxh)       return 4'h4;
    else if (m_ier[1] && m_pend)    return 4'h2;
    else if (m_ier[3] && msr_delta) return 4'h0;
    return 4'h1;
  endfunction

  // one clock with an optional access (op: 0 idle, 1 write, 2 read)
  task automatic tick(input int op, input logic [2:0] ofs, input logic [7:0] d);
    logic [7:0] nxt;
    logic set_p, clr_p, lrd;
    acc_wr = (op == 1); acc_rd = (op == 2); acc_ofs = ofs; acc_wdata = d;
    // R12: value registered at this edge from present state and inputs
    nxt = {{2{fifo_en}}, 2'b00, exp_code()};
    set_p = (acc_wr && ofs == 3'd1 && !div_sel && thr_empty) || tx_drained;
    clr_p = (acc_wr && ofs == 3'd0 && !div_sel) || (acc_rd && ofs == 3'd2 && m_iir[3:0] == 4'h2);
    if (set_p) m_pend = 1'b1; else if (clr_p) m_pend = 1'b0;
    lrd = acc_rd && ofs == 3'd5;
    if (brk_set) m_brk = 1'b1; else if (lrd) m_brk = 1'b0;
    if (ovr_set) m_ovr = 1'b1; else if (lrd) m_ovr = 1'b0;
    if (acc_wr && ofs == 3'd1 && !div_sel) m_ier = d[3:0];
    m_iir = nxt;
    @(posedge clk);
    @(negedge clk);
    acc_wr = 0; acc_rd = 0; brk_set = 0; ovr_set = 0; tx_drained = 0;
    chk("R3 R12 code", {4'h0, iir[3:0]}, {4'h0, m_iir[3:0]});
    chk("R6 upper bits", {iir[7:4], 4'h0}, {m_iir[7:4], 4'h0});
    chk("R7 irq", {7'h0, irq}, {7'h0, (m_iir[3:0] != 4'h1)});
    chk("R2 enable reg", {4'h0, ier}, {4'h0, m_ier});
    chk("R11 line flags", {4'h0, lsr_err}, {4'h0, m_brk, frm_err, par_err, m_ovr});
  endtask

  task automatic quiet();
    div_sel = 0; fifo_en = 0; rx_ready = 0; rx_tmo = 0; rx_count = '0; rx_trig = '0;
    par_err = 0; frm_err = 0; thr_empty = 0; msr_delta = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    rst_n = 0; acc_wr = 0; acc_rd = 0; acc_ofs = 0; acc_wdata = 0;
    brk_set = 0; ovr_set = 0; tx_drained = 0;
    quiet();
    m_ier = 0; m_pend = 0; m_brk = 0; m_ovr = 0; m_iir = 8'h01;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 iir", iir, 8'h01);
    chk("R1 ier", {4'h0, ier}, 8'h00);
    chk("R1 irq", {7'h0, irq}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    chk("R1 flags", {4'h0, lsr_err}, 8'h00);

    // R2: upper bits dropped, divisor mode ignored
    tick(1, 3'd1, 8'hF0);
    chk("R2 upper dropped", {4'h0, ier}, 8'h00);
    div_sel = 1; tick(1, 3'd1, 8'h0F); div_sel = 0;
    chk("R2 divisor ignored", {4'h0, ier}, 8'h00);

    // R8: enable write with holding empty sets pending
    thr_empty = 1; tick(1, 3'd1, 8'h02); tick(0, 0, 0);
    chk("R8 thre shown", iir, 8'h02);
    // R9: ident read while 0x2 shown clears it
    tick(2, 3'd2, 0); tick(0, 0, 0);
    chk("R9 cleared", iir, 8'h01);
    // R8: drained event sets again
    tx_drained = 1; tick(0, 0, 0); tick(0, 0, 0);
    chk("R8 drained", iir, 8'h02);
    // R10: holding write clears; with drained event in same cycle, set wins
    tick(1, 3'd0, 8'h55); tick(0, 0, 0);
    chk("R10 hold clear", iir, 8'h01);
    tx_drained = 1; tick(1, 3'd0, 8'h55); tick(0, 0, 0);
    chk("R10 set wins", iir, 8'h02);
    // R9: ident read while other code shown leaves pending
    tick(1, 3'd1, 8'h06); brk_set = 1; tick(0, 0, 0); tick(0, 0, 0);
    chk("R3 lstat over thre", iir, 8'h06);
    tick(2, 3'd2, 0);
    // R11: read with simultaneous break keeps it
    brk_set = 1; tick(2, 3'd5, 0);
    chk("R11 set wins", {4'h0, lsr_err}, 8'h08);
    tick(2, 3'd5, 0); tick(0, 0, 0);
    chk("R9 pending kept", iir, 8'h02);
    // R11: parity/framing are live levels
    par_err = 1; frm_err = 1; tick(2, 3'd5, 0);
    chk("R11 live levels", {4'h0, lsr_err}, 8'h06);
    par_err = 0; frm_err = 0; thr_empty = 0;
    tick(1, 3'd0, 8'h00);

    // R4: FIFO trigger level
    fifo_en = 1; rx_ready = 1; rx_trig = 5'd4; rx_count = 5'd3;
    tick(1, 3'd1, 8'h01); tick(0, 0, 0);
    chk("R4 below trigger", iir, 8'hC1);
    rx_count = 5'd4; tick(0, 0, 0); tick(0, 0, 0);
    chk("R4 at trigger", iir, 8'hC4);
    fifo_en = 0; rx_count = 5'd0; tick(0, 0, 0); tick(0, 0, 0);
    chk("R4 no fifo", iir, 8'h04);
    // R5: timeout masked by enable bit 0
    rx_ready = 0; rx_tmo = 1; fifo_en = 1; tick(1, 3'd1, 8'h0E); tick(0, 0, 0);
    chk("R5 masked", iir, 8'hC1);
    tick(1, 3'd1, 8'h01); tick(0, 0, 0);
    chk("R5 timeout", iir, 8'hCC);
    // R3: modem lowest
    rx_tmo = 0; msr_delta = 1; tick(1, 3'd1, 8'h08); tick(0, 0, 0);
    chk("R3 modem", iir, 8'hC0);
    chk("R7 modem irq", {7'h0, irq}, 8'h01);
    quiet();

    // random cycles
    for (int i = 0; i < 4000; i++) begin
      int op;
      div_sel = ($urandom % 4) == 0;
      fifo_en = $urandom % 2; rx_ready = $urandom % 2; rx_tmo = ($urandom % 4) == 0;
      rx_count = $urandom % 17; rx_trig = ($urandom % 2) ? 5'd1 << ($urandom % 4) : 5'd14;
      brk_set = ($urandom % 8) == 0; ovr_set = ($urandom % 8) == 0;
      par_err = ($urandom % 8) == 0; frm_err = ($urandom % 8) == 0;
      thr_empty = $urandom % 2; tx_drained = ($urandom % 6) == 0;
      msr_delta = $urandom % 2;
      op = $urandom % 3;
      case ($urandom % 5)
        0: tick(op, 3'd0, 8'($urandom));
        1: tick(op, 3'd1, 8'($urandom));
        2: tick(op, 3'd2, 8'($urandom));
        3: tick(op, 3'd5, 8'($urandom));
        default: tick(op, 3'($urandom), 8'($urandom));
      endcase
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule